// File: doc/BRIEF.md
# Response Timeout Tracker

This block tracks outbound requests that expect a reply and reports any request whose reply does not come back in time. A request is only armed when such a request actually leaves; idle periods and packets that need no reply never start a timer. Late replies are the only thing judged. Link health is not assessed, and the block raises no link fault.

Time is measured in coarse units. A programmable prescaler divides the bus clock by `presc_sel + 1` to form a scaled tick, and a fixed divide-by-15 stage turns fifteen scaled ticks into one unit. Each of the `2**TAG_W` outstanding slots, selected by the request tag, holds its own unit counter. A slot times out after `tval_cfg` units. A value of zero counts as one, and values above the field maximum `2**TVAL_W - 1` are clamped to that maximum. When a slot times out, a one-cycle strobe carries its tag and the slot is freed. If more than one slot expires in the same cycle, the strobes leave one per cycle, lowest tag first.

All inputs and outputs are plain strobes and levels. There is no ready signal, so the block applies no back-pressure: every request and response strobe is taken in the cycle it is high. Each timeout strobe is offered for exactly one cycle.

Top module: `resp_timeout_tracker`

## Requirements
- R1: The scaled tick occurs every `presc_sel + 1` clock cycles and one unit every 15 scaled ticks. Both counters are free-running from reset, so unit edges are the edges with index e (counting from 0 at the first edge after reset) where e mod (15·(presc_sel+1)) equals 15·(presc_sel+1) − 1.
- R2: A request armed at edge a with limit T raises `tmo_valid` after edge u+1, where u is the T-th unit edge strictly after a. An arm on a unit edge restarts the count at zero.
- R3: A `tval_cfg` of 0 behaves exactly like 1.
- R4: A `tval_cfg` above `2**TVAL_W - 1` behaves exactly like `2**TVAL_W - 1`.
- R5: Without `req_valid`, no slot becomes busy and no timeout is ever reported.
- R6: A response whose tag matches a busy slot frees it at that edge, and that slot then reports no timeout. A response to an idle tag changes nothing.
- R7: `tmo_valid` is high for one cycle per expiry with `tmo_tag` equal to the slot tag. The slot is free in the same cycle `tmo_valid` is seen.
- R8: A request to a busy tag raises `overflow_err` for one cycle after that edge and restarts the slot, which then times out relative to the new arm edge. A request to an idle tag leaves `overflow_err` low.
- R9: `busy_count` equals the number of busy slots, never more than `2**TAG_W`.
- R10: Slots expiring on the same unit edge report in consecutive cycles in ascending tag order.
- R11: While `rst_n` is low at a clock edge, all slots, the prescaler and the outputs return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A reply-requiring request was sent this cycle |
| req_tag | input | TAG_W | Slot tag of that request |
| rsp_valid | input | 1 | A reply was received this cycle |
| rsp_tag | input | TAG_W | Slot tag of that reply |
| presc_sel | input | PRESC_W | Prescaler select; scaled tick = clock / (presc_sel+1) |
| tval_cfg | input | CFG_W | Timeout in units of 15 scaled ticks |
| tmo_valid | output | 1 | One-cycle timeout strobe |
| tmo_tag | output | TAG_W | Tag of the timed-out slot |
| overflow_err | output | 1 | One-cycle strobe: request hit a busy tag |
| busy_count | output | $clog2(2**TAG_W+1) | Number of busy slots |

## Verification
The hardest case to reach is several slots expiring on the same unit edge, because that needs every arm to fall inside one unit window. The bench arms three tags on the first three edges after reset with the smallest prescaler and a limit of one, so all three expire at edge 14. It then expects strobes on edges 15, 16 and 17. Exact timeout edges are predicted from the free-running phase, counted from reset, for a sweep of prescaler and limit values, including the zero and over-range limits.

// File: rtl/rtt_pkg.sv
`timescale 1ns/1ps
package rtt_pkg;
  // scaled ticks per counting unit
  localparam int unsigned UNIT_DIV = 15;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RUN  = 2'd1,
    SLOT_DUE  = 2'd2
  } slot_state_t;
endpackage

// File: rtl/rtt_prescaler.sv
`timescale 1ns/1ps
module rtt_prescaler #(
  parameter int PRESC_W = 4,
  parameter int GROUP   = rtt_pkg::UNIT_DIV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc_sel,
  output logic               unit_tick
);
  localparam int DC_W = $clog2(GROUP);

  logic [PRESC_W-1:0] pc_q;
  logic [DC_W-1:0]    dc_q;
  logic               scaled_tick;

  assign scaled_tick = (pc_q >= presc_sel);
  assign unit_tick   = scaled_tick && (dc_q == DC_W'(GROUP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      dc_q <= '0;
    end else begin
      pc_q <= scaled_tick ? '0 : pc_q + 1'b1;
      if (scaled_tick)
        dc_q <= (dc_q == DC_W'(GROUP - 1)) ? '0 : dc_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtt_slot.sv
`timescale 1ns/1ps
module rtt_slot #(
  parameter int TVAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              clr,
  input  logic              grant,
  input  logic              unit_tick,
  input  logic [TVAL_W-1:0] limit,
  output logic              busy,
  output logic              due
);
  import rtt_pkg::*;

  slot_state_t       st_q;
  logic [TVAL_W-1:0] cnt_q;
  logic [TVAL_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign busy   = (st_q != SLOT_IDLE);
  assign due    = (st_q == SLOT_DUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SLOT_IDLE;
      cnt_q <= '0;
    end else if (arm) begin
      st_q  <= SLOT_RUN;
      cnt_q <= '0;
    end else if (clr || grant) begin
      st_q  <= SLOT_IDLE;
      cnt_q <= '0;
    end else if (st_q == SLOT_RUN && unit_tick) begin
      cnt_q <= cnt_nx[TVAL_W-1:0];
      if (cnt_nx >= {1'b0, limit})
        st_q <= SLOT_DUE;
    end
  end
endmodule

// File: rtl/rtt_arbiter.sv
`timescale 1ns/1ps
module rtt_arbiter #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/resp_timeout_tracker.sv
`timescale 1ns/1ps
module resp_timeout_tracker #(
  parameter int TAG_W   = 2,
  parameter int PRESC_W = 4,
  parameter int TVAL_W  = 4,
  parameter int CFG_W   = TVAL_W + 2,
  localparam int SLOTS  = 1 << TAG_W,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic               rsp_valid,
  input  logic [TAG_W-1:0]   rsp_tag,
  input  logic [PRESC_W-1:0] presc_sel,
  input  logic [CFG_W-1:0]   tval_cfg,
  output logic               tmo_valid,
  output logic [TAG_W-1:0]   tmo_tag,
  output logic               overflow_err,
  output logic [CNT_W-1:0]   busy_count
);
  // CFG_W must exceed TVAL_W so that over-range values can be presented
  localparam logic [CFG_W-1:0] LIM_MAX = {{(CFG_W - TVAL_W){1'b0}}, {TVAL_W{1'b1}}};

  logic [TVAL_W-1:0] limit;
  logic              unit_tick;
  logic [SLOTS-1:0]  arm_vec, clr_vec, busy_vec, due_vec, elig_vec, grant_vec;
  logic              grant_any;
  logic [TAG_W-1:0]  grant_idx;

  always_comb begin
    if (tval_cfg == '0)          limit = TVAL_W'(1);
    else if (tval_cfg > LIM_MAX) limit = LIM_MAX[TVAL_W-1:0];
    else                         limit = tval_cfg[TVAL_W-1:0];
  end

  rtt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_sel (presc_sel),
    .unit_tick (unit_tick)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign arm_vec[g]  = req_valid && (req_tag == TAG_W'(g));
    assign clr_vec[g]  = rsp_valid && (rsp_tag == TAG_W'(g));
    assign elig_vec[g] = due_vec[g] && !arm_vec[g] && !clr_vec[g];

    rtt_slot #(.TVAL_W(TVAL_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm_vec[g]),
      .clr       (clr_vec[g]),
      .grant     (grant_vec[g]),
      .unit_tick (unit_tick),
      .limit     (limit),
      .busy      (busy_vec[g]),
      .due       (due_vec[g])
    );
  end

  rtt_arbiter #(.N(SLOTS), .IDX_W(TAG_W)) u_arb (
    .req   (elig_vec),
    .grant (grant_vec),
    .any   (grant_any),
    .idx   (grant_idx)
  );

  always_comb begin
    busy_count = '0;
    for (int i = 0; i < SLOTS; i++)
      busy_count = busy_count + CNT_W'(busy_vec[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_valid    <= 1'b0;
      tmo_tag      <= '0;
      overflow_err <= 1'b0;
    end else begin
      tmo_valid    <= grant_any;
      tmo_tag      <= grant_any ? grant_idx : '0;
      overflow_err <= req_valid && busy_vec[req_tag];
    end
  end
endmodule

// File: rtl/rtt_checker.sv
`timescale 1ns/1ps
module rtt_checker #(
  parameter int TAG_W   = 2,
  localparam int SLOTS  = 1 << TAG_W,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [TAG_W-1:0] req_tag,
  input logic             rsp_valid,
  input logic [TAG_W-1:0] rsp_tag,
  input logic             tmo_valid,
  input logic [TAG_W-1:0] tmo_tag,
  input logic             overflow_err,
  input logic [CNT_W-1:0] busy_count
);
  p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_count <= CNT_W'(SLOTS));

  p_no_arm_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> busy_count <= $past(busy_count));

  p_ovf_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |-> $past(req_valid) && ($past(busy_count) != '0));

  p_tmo_had_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_valid |-> $past(busy_count) != '0);

  p_tmo_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_valid && !$past(req_valid)) |-> busy_count < $past(busy_count));

  p_rsp_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !req_valid) |=> busy_count <= $past(busy_count));

  p_idle_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_valid |-> tmo_tag == '0);

  logic unused_ok;
  assign unused_ok = ^{req_tag, rsp_tag};
endmodule

bind resp_timeout_tracker rtt_checker #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/resp_timeout_tracker_test.sv
`timescale 1ns/1ps
module resp_timeout_tracker_test;
  localparam int TAG_W = 2, PRESC_W = 4, TVAL_W = 4, CFG_W = 6;
  localparam int CNT_W = 3, LMAX = 15, DIV = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_valid = 1'b0;
  logic [TAG_W-1:0] req_tag = '0, rsp_tag = '0;
  logic [PRESC_W-1:0] presc_sel = '0;
  logic [CFG_W-1:0] tval_cfg = '0;
  logic tmo_valid, overflow_err;
  logic [TAG_W-1:0] tmo_tag;
  logic [CNT_W-1:0] busy_count;
  int ecnt = 0, n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) ecnt <= rst_n ? ecnt + 1 : 0;

  resp_timeout_tracker #(.TAG_W(TAG_W), .PRESC_W(PRESC_W), .TVAL_W(TVAL_W), .CFG_W(CFG_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .presc_sel(presc_sel), .tval_cfg(tval_cfg),
    .tmo_valid(tmo_valid), .tmo_tag(tmo_tag), .overflow_err(overflow_err), .busy_count(busy_count));

  task automatic check_eq(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int eff_lim(input int t);
    return (t == 0) ? 1 : (t > LMAX ? LMAX : t);
  endfunction

  function automatic int exp_edge(input int a, input int t, input int p);
    int l = DIV * (p + 1);
    int u1 = a + 1 + (l - 1 - ((a + 1) % l));
    return u1 + (eff_lim(t) - 1) * l + 1;
  endfunction

  task automatic do_reset(input int p, input int t);
    rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0;
    presc_sel = PRESC_W'(p); tval_cfg = CFG_W'(t);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_req(input int tag, output int a);
    req_valid = 1'b1; req_tag = TAG_W'(tag); a = ecnt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_tmo(output int edge_seen);
    int k = 0;
    while (!tmo_valid && k < 6000) begin @(negedge clk); k++; end
    edge_seen = tmo_valid ? ecnt - 1 : -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a, a2, e, seen;
    int tv[6] = '{0, 1, 2, 5, 15, 40};
    // R11 reset state
    do_reset(0, 1);
    check_eq("R11 tmo_valid", int'(tmo_valid), 0);
    check_eq("R11 busy_count", int'(busy_count), 0);
    check_eq("R11 overflow_err", int'(overflow_err), 0);

    // sweep of prescaler and limit: R1 R2 R3 R4 R7 R9
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 6; i++) begin
        string rq;
        int tag = i % 4;
        rq = (tv[i] == 0) ? "R3" : (tv[i] > LMAX ? "R4" : (p == 0 ? "R2" : "R1"));
        do_reset(p, tv[i]);
        repeat (p * 7 + i) @(negedge clk);
        send_req(tag, a);
        check_eq("R9 busy after arm", int'(busy_count), 1);
        check_eq("R8 no overflow on idle tag", int'(overflow_err), 0);
        wait_tmo(seen);
        check_eq(rq, seen, exp_edge(a, tv[i], p));
        check_eq("R7 tmo_tag", int'(tmo_tag), tag);
        check_eq("R7 slot freed", int'(busy_count), 0);
        @(negedge clk);
        check_eq("R7 one-cycle strobe", int'(tmo_valid), 0);
      end
    end

    // R5 idle never times out; R6 response to idle tag ignored
    do_reset(0, 1);
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      rsp_valid = (k == 20); rsp_tag = 2'd3;
      @(negedge clk);
      if (tmo_valid) seen++;
    end
    rsp_valid = 1'b0;
    check_eq("R5 no timeout while idle", seen, 0);
    check_eq("R6 idle response ignored", int'(busy_count), 0);

    // R6 matching response clears slot
    do_reset(0, 3);
    send_req(1, a);
    repeat (10) @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = 2'd1;
    @(negedge clk);
    rsp_valid = 1'b0;
    check_eq("R6 busy after response", int'(busy_count), 0);
    seen = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (tmo_valid) seen++; end
    check_eq("R6 no timeout after response", seen, 0);

    // R8 request to busy tag
    do_reset(1, 2);
    send_req(2, a);
    repeat (25) @(negedge clk);
    send_req(2, a2);
    check_eq("R8 overflow pulse", int'(overflow_err), 1);
    check_eq("R8 busy unchanged", int'(busy_count), 1);
    @(negedge clk);
    check_eq("R8 overflow one cycle", int'(overflow_err), 0);
    wait_tmo(seen);
    check_eq("R8 restart timing", seen, exp_edge(a2, 2, 1));
    check_eq("R8 tmo_tag", int'(tmo_tag), 2);

    // R10 same-edge expiry, ascending order
    do_reset(0, 1);
    req_valid = 1'b1; req_tag = 2'd0; @(negedge clk);
    req_tag = 2'd1; @(negedge clk);
    req_tag = 2'd2; @(negedge clk);
    req_valid = 1'b0;
    check_eq("R9 three busy", int'(busy_count), 3);
    wait_tmo(seen);
    check_eq("R10 first edge", seen, 15);
    check_eq("R10 first tag", int'(tmo_tag), 0);
    check_eq("R10 busy 2", int'(busy_count), 2);
    @(negedge clk);
    check_eq("R10 second valid", int'(tmo_valid), 1);
    check_eq("R10 second tag", int'(tmo_tag), 1);
    @(negedge clk);
    check_eq("R10 third valid", int'(tmo_valid), 1);
    check_eq("R10 third tag", int'(tmo_tag), 2);
    check_eq("R10 all free", int'(busy_count), 0);
    @(negedge clk);
    check_eq("R10 strobes done", int'(tmo_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule